// File: doc/BRIEF.md
# Ordered Store Buffer with Load Forwarding

This block sits between one core's memory request port and its data cache. It enforces total store ordering. Stores are queued and written to the cache strictly in the order the core issued them. A load does not have to wait for older queued stores to other addresses: it reads the cache at once. A load to a word that is still queued gets its data from the youngest queued copy, before any other core can observe that store.

Fences and atomic swaps (read-modify-write) are ordering points. Neither is accepted until the queue is empty. An atomic swap reads the cache and then writes it in the very next step, and no other request is accepted in between.

The core presents one request at a time and holds it until `reqReady` is high. Loads, fences and swaps answer with a one-cycle `rspValid` pulse. Stores get no response. The queue depth `DEPTH` must be a power of two, at least 2. The cache read port is combinational: `crRdata` must return the word at `crAddr` in the same cycle.

Top module: `tsoStoreBuffer`

## Requirements
- R1: A store (reqOp 1) is accepted whenever fewer than DEPTH stores are queued. With DEPTH stores queued, reqReady stays low for a store.
- R2: Queued stores appear on the cache write port oldest first, one entry per cycle in which cwReady is high. While cwValid is high and cwReady is low, cwAddr, cwData and cwBe hold their values.
- R3: A load (reqOp 0) whose word address matches no queued store is accepted at once, even while other stores are queued. It drives crValid in the accepting cycle, and rspValid with the cache word follows one cycle later.
- R4: A load that matches queued stores, where the youngest matching store has all byte enables set, is accepted without a cache read. The next cycle it returns that youngest store's data.
- R5: A load whose youngest matching store has a partial byte-enable mask is held off (reqReady low, crValid low) until no matching store is queued. It then reads the cache, which by then holds the merged word.
- R6: A fence (reqOp 2) is accepted only when the queue is empty. It is answered one cycle later with rspValid and rspData equal to zero.
- R7: A swap (reqOp 3) is accepted only when the queue is empty. In that cycle it reads the cache. From the next cycle on it drives reqData/reqBe to its address on the write port until cwReady. One cycle after the write it returns the old word. No request is accepted while the write is pending.
- R8: After reset the queue is empty: cwValid and rspValid are low, and a fence is accepted immediately.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Core request present |
| reqOp | input | 2 | 0 load, 1 store, 2 fence, 3 swap |
| reqAddr | input | ADDR_W | Word address |
| reqData | input | DATA_W | Store or swap data |
| reqBe | input | DATA_W/8 | Byte enables for store or swap |
| reqReady | output | 1 | Request accepted this cycle |
| rspValid | output | 1 | Response pulse for load, fence, swap |
| rspData | output | DATA_W | Response data |
| cwValid | output | 1 | Cache write request |
| cwAddr | output | ADDR_W | Cache write address |
| cwData | output | DATA_W | Cache write data |
| cwBe | output | DATA_W/8 | Cache write byte enables |
| cwReady | input | 1 | Cache takes the write this cycle |
| crValid | output | 1 | Cache read request |
| crAddr | output | ADDR_W | Cache read address |
| crRdata | input | DATA_W | Cache read data, same cycle |

## Verification
The hardest cases to reach are a load held against a partial-mask store and a swap whose write phase is back-pressured. Both need the queue kept occupied, or the write port kept stalled, while another request waits. The bench controls cwReady directly. It holds cwReady low to build up several stores, including two to one word and a partial one, and then issues loads and fences against that backlog. For the swap, it offers a competing load while the swap's write is still pending and checks that the load is held off.

// File: rtl/tsoSbPkg.sv
package tsoSbPkg;
  typedef enum logic [1:0] {
    OP_LOAD  = 2'd0,
    OP_STORE = 2'd1,
    OP_FENCE = 2'd2,
    OP_SWAP  = 2'd3
  } memOpE;

  // strobes from control to datapath
  typedef struct packed {
    logic push;
    logic pop;
    logic rspCache;
    logic rspFwd;
    logic rspFence;
    logic rspSwap;
    logic swapCapture;
    logic selSwap;
  } sbCtlT;
endpackage

// File: rtl/tsoSbDatapath.sv
module tsoSbDatapath
  import tsoSbPkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  sbCtlT                    ctl,
  input  logic [ADDR_W-1:0]        reqAddr,
  input  logic [DATA_W-1:0]        reqData,
  input  logic [DATA_W/8-1:0]      reqBe,
  input  logic [DATA_W-1:0]        crRdata,
  output logic                     full,
  output logic                     empty,
  output logic                     hitAny,
  output logic                     fwdOk,
  output logic [ADDR_W-1:0]        cwAddr,
  output logic [DATA_W-1:0]        cwData,
  output logic [DATA_W/8-1:0]      cwBe,
  output logic [ADDR_W-1:0]        crAddr,
  output logic                     rspValid,
  output logic [DATA_W-1:0]        rspData
);
  localparam int BE_W  = DATA_W / 8;
  localparam int IDX_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [ADDR_W-1:0] entAddr [DEPTH];
  logic [DATA_W-1:0] entData [DEPTH];
  logic [BE_W-1:0]   entBe   [DEPTH];
  logic [IDX_W-1:0]  rdIdx, wrIdx, fwdIdx;
  logic [CNT_W-1:0]  count;

  logic [ADDR_W-1:0] swapAddr;
  logic [DATA_W-1:0] swapData, swapOld;
  logic [BE_W-1:0]   swapBe;

  // one register slot per queue entry
  for (genvar g = 0; g < DEPTH; g++) begin : gSlot
    always_ff @(posedge clk) begin
      if (ctl.push && wrIdx == IDX_W'(g)) begin
        entAddr[g] <= reqAddr;
        entData[g] <= reqData;
        entBe[g]   <= reqBe;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdIdx <= '0;
      wrIdx <= '0;
      count <= '0;
    end else begin
      if (ctl.push) wrIdx <= wrIdx + 1'b1;
      if (ctl.pop)  rdIdx <= rdIdx + 1'b1;
      count <= count + CNT_W'(ctl.push) - CNT_W'(ctl.pop);
    end
  end

  assign full  = (count == CNT_W'(DEPTH));
  assign empty = (count == '0);

  // scan oldest to youngest; the last hit is the youngest match
  always_comb begin
    hitAny = 1'b0;
    fwdIdx = '0;
    for (int k = 0; k < DEPTH; k++) begin
      if (CNT_W'(k) < count && entAddr[rdIdx + IDX_W'(k)] == reqAddr) begin
        hitAny = 1'b1;
        fwdIdx = rdIdx + IDX_W'(k);
      end
    end
  end

  assign fwdOk = hitAny && (&entBe[fwdIdx]);

  always_ff @(posedge clk) begin
    if (ctl.swapCapture) begin
      swapAddr <= reqAddr;
      swapData <= reqData;
      swapBe   <= reqBe;
      swapOld  <= crRdata;
    end
  end

  assign crAddr = reqAddr;
  assign cwAddr = ctl.selSwap ? swapAddr : entAddr[rdIdx];
  assign cwData = ctl.selSwap ? swapData : entData[rdIdx];
  assign cwBe   = ctl.selSwap ? swapBe   : entBe[rdIdx];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspData  <= '0;
    end else begin
      rspValid <= ctl.rspCache | ctl.rspFwd | ctl.rspFence | ctl.rspSwap;
      if (ctl.rspCache)      rspData <= crRdata;
      else if (ctl.rspFwd)   rspData <= entData[fwdIdx];
      else if (ctl.rspSwap)  rspData <= swapOld;
      else if (ctl.rspFence) rspData <= '0;
    end
  end
endmodule

// File: rtl/tsoSbControl.sv
module tsoSbControl
  import tsoSbPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [1:0] reqOp,
  input  logic       cwReady,
  input  logic       full,
  input  logic       empty,
  input  logic       hitAny,
  input  logic       fwdOk,
  output logic       reqReady,
  output logic       crValid,
  output logic       cwValid,
  output sbCtlT      ctl
);
  typedef enum logic {ST_RUN, ST_SWAP_WR} stE;
  stE st, stNext;

  always_ff @(posedge clk) begin
    if (!rstN) st <= ST_RUN;
    else       st <= stNext;
  end

  always_comb begin
    ctl      = '0;
    reqReady = 1'b0;
    crValid  = 1'b0;
    cwValid  = 1'b0;
    stNext   = st;
    case (st)
      ST_RUN: begin
        cwValid = !empty;
        ctl.pop = !empty && cwReady;
        if (reqValid) begin
          case (memOpE'(reqOp))
            OP_LOAD: begin
              if (!hitAny) begin
                reqReady = 1'b1;
                crValid  = 1'b1;
                ctl.rspCache = 1'b1;
              end else if (fwdOk) begin
                reqReady   = 1'b1;
                ctl.rspFwd = 1'b1;
              end
            end
            OP_STORE: begin
              if (!full) begin
                reqReady = 1'b1;
                ctl.push = 1'b1;
              end
            end
            OP_FENCE: begin
              if (empty) begin
                reqReady     = 1'b1;
                ctl.rspFence = 1'b1;
              end
            end
            default: begin
              if (empty) begin
                reqReady        = 1'b1;
                crValid         = 1'b1;
                ctl.swapCapture = 1'b1;
                stNext          = ST_SWAP_WR;
              end
            end
          endcase
        end
      end
      default: begin
        cwValid     = 1'b1;
        ctl.selSwap = 1'b1;
        if (cwReady) begin
          ctl.rspSwap = 1'b1;
          stNext      = ST_RUN;
        end
      end
    endcase
  end
endmodule

// File: rtl/tsoStoreBuffer.sv
module tsoStoreBuffer
  import tsoSbPkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  input  logic [1:0]          reqOp,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [DATA_W-1:0]   reqData,
  input  logic [DATA_W/8-1:0] reqBe,
  output logic                reqReady,
  output logic                rspValid,
  output logic [DATA_W-1:0]   rspData,
  output logic                cwValid,
  output logic [ADDR_W-1:0]   cwAddr,
  output logic [DATA_W-1:0]   cwData,
  output logic [DATA_W/8-1:0] cwBe,
  input  logic                cwReady,
  output logic                crValid,
  output logic [ADDR_W-1:0]   crAddr,
  input  logic [DATA_W-1:0]   crRdata
);
  sbCtlT ctl;
  logic  sbFull, sbEmpty, hitAny, fwdOk;

  tsoSbControl ctrl_i (
    .clk, .rstN, .reqValid, .reqOp, .cwReady,
    .full(sbFull), .empty(sbEmpty), .hitAny, .fwdOk,
    .reqReady, .crValid, .cwValid, .ctl
  );

  tsoSbDatapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) dp_i (
    .clk, .rstN, .ctl, .reqAddr, .reqData, .reqBe, .crRdata,
    .full(sbFull), .empty(sbEmpty), .hitAny, .fwdOk,
    .cwAddr, .cwData, .cwBe, .crAddr, .rspValid, .rspData
  );
endmodule

// File: rtl/tsoSbChecker.sv
module tsoSbChecker #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic                clk,
  input logic                rstN,
  input logic                reqValid,
  input logic [1:0]          reqOp,
  input logic                reqReady,
  input logic                rspValid,
  input logic                cwValid,
  input logic [ADDR_W-1:0]   cwAddr,
  input logic [DATA_W-1:0]   cwData,
  input logic [DATA_W/8-1:0] cwBe,
  input logic                cwReady,
  input logic                crValid,
  input logic                sbFull,
  input logic                sbEmpty
);
  logic acc;
  assign acc = reqValid && reqReady;

  assert_store_not_full_R1: assert property (@(posedge clk) disable iff (!rstN)
    acc && reqOp == 2'd1 |-> !sbFull);

  assert_head_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    cwValid && !cwReady |=> cwValid && $stable(cwAddr) && $stable(cwData) && $stable(cwBe));

  assert_load_rsp_R3: assert property (@(posedge clk) disable iff (!rstN)
    acc && reqOp == 2'd0 |=> rspValid);

  assert_fwd_needs_entry_R4: assert property (@(posedge clk) disable iff (!rstN)
    acc && reqOp == 2'd0 && !crValid |-> !sbEmpty);

  assert_fence_empty_R6: assert property (@(posedge clk) disable iff (!rstN)
    acc && reqOp == 2'd2 |-> sbEmpty && !cwValid);

  assert_swap_write_R7: assert property (@(posedge clk) disable iff (!rstN)
    acc && reqOp == 2'd3 |=> cwValid && !reqReady);
endmodule

bind tsoStoreBuffer tsoSbChecker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (.*);

// File: tb/tsoStoreBuffer_tb_top.sv
`timescale 1ns/1ps
module tsoStoreBuffer_tb_top;
  localparam logic [1:0] LD = 2'd0, ST = 2'd1, FN = 2'd2, SW = 2'd3;

  typedef struct packed {
    logic [1:0]  op;
    logic [3:0]  addr;
    logic [31:0] data;
    logic [3:0]  be;
    logic        rdy;
    logic [31:0] exp;
    logic [3:0]  reqNo;
  } vecT;

  localparam vecT VECS [12] = '{
    '{ST, 4'd1, 32'h11111111, 4'hF, 1'b0, 32'h0, 4'd1},        // R1 queue
    '{ST, 4'd2, 32'h22222222, 4'hF, 1'b0, 32'h0, 4'd1},
    '{ST, 4'd1, 32'h33333333, 4'hF, 1'b0, 32'h0, 4'd1},
    '{LD, 4'd1, 32'h0,        4'h0, 1'b0, 32'h33333333, 4'd4}, // R4 youngest
    '{LD, 4'd5, 32'h0,        4'h0, 1'b0, 32'hA0000005, 4'd3}, // R3 bypass
    '{LD, 4'd2, 32'h0,        4'h0, 1'b0, 32'h22222222, 4'd4},
    '{ST, 4'd3, 32'h44444444, 4'h3, 1'b0, 32'h0, 4'd1},
    '{FN, 4'd0, 32'h0,        4'h0, 1'b1, 32'h0, 4'd6},        // R6 drain
    '{LD, 4'd1, 32'h0,        4'h0, 1'b1, 32'h33333333, 4'd3},
    '{LD, 4'd3, 32'h0,        4'h0, 1'b1, 32'hA0004444, 4'd3},
    '{SW, 4'd2, 32'h55555555, 4'hF, 1'b1, 32'h22222222, 4'd7}, // R7 swap
    '{LD, 4'd2, 32'h0,        4'h0, 1'b1, 32'h55555555, 4'd3}
  };

  logic        clk = 1'b0, rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [1:0]  reqOp = 2'd0;
  logic [31:0] reqAddr = '0, reqData = '0;
  logic [3:0]  reqBe = '0;
  logic        reqReady, rspValid, cwValid, crValid;
  logic [31:0] rspData, cwAddr, cwData, crAddr, crRdata;
  logic [3:0]  cwBe;
  logic        cwReadyDrv = 1'b0;

  logic [31:0] mem [16];
  logic [31:0] logAddr [32];
  logic [31:0] logData [32];
  int          logN = 0;
  int          nChecks = 0, nFail = 0;

  always #2.5 clk = ~clk;

  tsoStoreBuffer dut_i (
    .clk, .rstN, .reqValid, .reqOp, .reqAddr, .reqData, .reqBe, .reqReady,
    .rspValid, .rspData, .cwValid, .cwAddr, .cwData, .cwBe,
    .cwReady(cwReadyDrv), .crValid, .crAddr, .crRdata
  );

  assign crRdata = mem[crAddr[3:0]];

  always @(posedge clk) begin
    if (rstN && cwValid && cwReadyDrv) begin
      for (int b = 0; b < 4; b++)
        if (cwBe[b]) mem[cwAddr[3:0]][8*b +: 8] <= cwData[8*b +: 8];
      if (logN < 32) begin
        logAddr[logN] <= cwAddr;
        logData[logN] <= cwData;
        logN <= logN + 1;
      end
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] op, input logic [31:0] addr, input logic [31:0] data,
                       input logic [3:0] be, output logic [31:0] rsp, output bit got);
    int guard;
    @(negedge clk);
    reqValid = 1'b1; reqOp = op; reqAddr = addr; reqData = data; reqBe = be;
    #0.5;
    guard = 0;
    while (!reqReady && guard < 200) begin
      @(negedge clk); #0.5; guard++;
    end
    got = reqReady;
    rsp = '0;
    if (!got) begin
      reqValid = 1'b0;
      return;
    end
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    if (op != ST) begin
      guard = 0;
      while (!rspValid && guard < 50) begin
        @(negedge clk); guard++;
      end
      got = rspValid;
      rsp = rspData;
    end
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
    finishRun();
  end

  initial begin
    logic [31:0] rsp;
    bit got;
    int base;
    for (int i = 0; i < 16; i++) mem[i] = 32'hA0000000 + i;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R8: reset state
    @(negedge clk);
    check(!cwValid && !rspValid, "R8 idle outputs", {30'd0, cwValid, rspValid}, 32'd0);
    issue(FN, 32'd0, 32'd0, 4'h0, rsp, got);
    check(got && rsp == 32'd0, "R8 fence on empty queue", rsp, 32'd0);

    // vector table
    for (int i = 0; i < 12; i++) begin
      cwReadyDrv = VECS[i].rdy;
      issue(VECS[i].op, {28'd0, VECS[i].addr}, VECS[i].data, VECS[i].be, rsp, got);
      if (VECS[i].op == ST) check(got, $sformatf("R%0d vector %0d accept", VECS[i].reqNo, i), {31'd0, got}, 32'd1);
      else check(got && rsp == VECS[i].exp, $sformatf("R%0d vector %0d", VECS[i].reqNo, i), rsp, VECS[i].exp);
    end
    // R2: write order of the table phase
    check(logN == 5, "R2 write count", logN, 5);
    check(logAddr[0] == 1 && logData[0] == 32'h11111111, "R2 order 0", logData[0], 32'h11111111);
    check(logAddr[1] == 2 && logData[1] == 32'h22222222, "R2 order 1", logData[1], 32'h22222222);
    check(logAddr[2] == 1 && logData[2] == 32'h33333333, "R2 order 2", logData[2], 32'h33333333);
    check(logAddr[3] == 3 && logData[3] == 32'h44444444, "R2 order 3", logData[3], 32'h44444444);
    check(logAddr[4] == 2 && logData[4] == 32'h55555555, "R7 swap write", logData[4], 32'h55555555);

    // R1: fill the queue
    cwReadyDrv = 1'b0;
    base = logN;
    for (int k = 0; k < 8; k++) begin
      issue(ST, 32'd8 + k, 32'hB0000000 + k, 4'hF, rsp, got);
      check(got, "R1 store accepted below depth", {31'd0, got}, 32'd1);
    end
    @(negedge clk);
    reqValid = 1'b1; reqOp = ST; reqAddr = 32'd0; reqData = 32'h0; reqBe = 4'hF;
    #0.5;
    check(!reqReady, "R1 store held when full", {31'd0, reqReady}, 32'd0);
    reqOp = FN;
    #0.5;
    check(!reqReady, "R6 fence held when nonempty", {31'd0, reqReady}, 32'd0);
    reqValid = 1'b0;
    check(cwValid && cwAddr == 32'd8, "R2 head presented", cwAddr, 32'd8);
    @(negedge clk);
    check(cwValid && cwAddr == 32'd8 && cwData == 32'hB0000000, "R2 head held", cwAddr, 32'd8);
    issue(LD, 32'd12, 32'd0, 4'h0, rsp, got);
    check(got && rsp == 32'hB0000004, "R4 forward while full", rsp, 32'hB0000004);
    cwReadyDrv = 1'b1;
    issue(FN, 32'd0, 32'd0, 4'h0, rsp, got);
    check(got && rsp == 32'd0, "R6 fence after drain", rsp, 32'd0);
    check(logN == base + 8, "R2 drained all", logN, base + 8);
    for (int k = 0; k < 8; k++)
      check(logAddr[base + k] == 32'd8 + k, "R2 drain order", logAddr[base + k], 32'd8 + k);

    // R5: partial-mask store blocks a load
    cwReadyDrv = 1'b0;
    issue(ST, 32'd4, 32'h000000EE, 4'h1, rsp, got);
    @(negedge clk);
    reqValid = 1'b1; reqOp = LD; reqAddr = 32'd4;
    #0.5;
    check(!reqReady && !crValid, "R5 load held", {30'd0, reqReady, crValid}, 32'd0);
    repeat (3) @(negedge clk);
    #0.5;
    check(!reqReady && !crValid, "R5 load still held", {30'd0, reqReady, crValid}, 32'd0);
    reqValid = 1'b0;
    cwReadyDrv = 1'b1;
    issue(LD, 32'd4, 32'd0, 4'h0, rsp, got);
    check(got && rsp == 32'hA00000EE, "R5 load after drain", rsp, 32'hA00000EE);

    // R7: swap write back-pressured, competing load held off
    cwReadyDrv = 1'b0;
    @(negedge clk);
    reqValid = 1'b1; reqOp = SW; reqAddr = 32'd6; reqData = 32'h66666666; reqBe = 4'hF;
    #0.5;
    check(reqReady && crValid, "R7 swap read on empty queue", {30'd0, reqReady, crValid}, 32'd3);
    @(posedge clk);
    @(negedge clk);
    reqOp = LD; reqAddr = 32'd7;
    #0.5;
    check(!reqReady && cwValid && cwAddr == 32'd6 && cwData == 32'h66666666,
          "R7 write pending blocks load", cwData, 32'h66666666);
    repeat (2) @(negedge clk);
    #0.5;
    check(!reqReady && !rspValid, "R7 still pending", {30'd0, reqReady, rspValid}, 32'd0);
    cwReadyDrv = 1'b1;
    reqValid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check(rspValid && rspData == 32'hA0000006, "R7 swap old value", rspData, 32'hA0000006);
    check(mem[6] == 32'h66666666, "R7 swap wrote cache", mem[6], 32'h66666666);
    issue(LD, 32'd7, 32'd0, 4'h0, rsp, got);
    check(got && rsp == 32'hA0000007, "R3 load after swap", rsp, 32'hA0000007);

    finishRun();
  end
endmodule